// File: doc/BRIEF.md
# Count Compare Interrupt Timer

This block is a processor-style interval timer. A 32-bit counter advances by one on each enable tick that arrives from an external prescaler, and wraps to zero past its all-ones value. Software can load the counter and a compare register directly through a write port. When a tick moves the counter onto the compare value, a sticky timer-pending bit is set. While that bit is set, one of eight interrupt lines is driven high.

A 3-bit line-select field, written through the same data bus, chooses which of the eight lines carries the interrupt. A count-disable input freezes the counter, and no match can occur while the counter is frozen. Writing the compare register is the only way to acknowledge the interrupt: the pending bit clears and the selected line drops. The usual pattern is to write the next deadline into compare. The wall-clock to tick conversion and the core's exception handling sit outside this block.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter reads 1, compare reads 0, the pending bit is 0 and every interrupt line is low.
- R2: On each cycle with `tick_i`=1, `freeze_i`=0 and `cnt_we_i`=0, the counter increases by exactly one. With `tick_i`=0 and no count write, the counter holds its value.
- R3: The counter is 32 bits wide and wraps from 0xFFFFFFFF to 0x00000000.
- R4: While `freeze_i`=1, the counter holds its value even when ticks arrive, and no match sets the pending bit.
- R5: The pending bit is set on the edge where an unfrozen tick moves the counter to a value equal to compare. The edge before that one leaves it clear.
- R6: `irq_o` is all zeros while the pending bit is 0. While the bit is 1, `irq_o` has exactly one bit set, at the index equal to the 3-bit select value. That value is loaded from `wdata_i[2:0]` on a cycle with `sel_we_i`=1 and is 0 after reset.
- R7: Once set, the pending bit stays set through further ticks until compare is written.
- R8: A cycle with `cmp_we_i`=1 loads compare from `wdata_i` and clears the pending bit, which lowers the selected line. The clear also wins over a match caused by a tick in that same cycle.
- R9: A cycle with `cnt_we_i`=1 loads the counter from `wdata_i`. The load takes priority over a tick in the same cycle.
- R10: Only a tick can cause a match. A counter that sits at the compare value does not match again, and neither does a counter that is loaded with the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable pulse from the prescaler |
| freeze_i | input | 1 | Count-disable: holds the counter and blocks matches |
| cnt_we_i | input | 1 | Load the counter from wdata_i |
| cmp_we_i | input | 1 | Load compare from wdata_i and clear the pending bit |
| sel_we_i | input | 1 | Load the line select from wdata_i[2:0] |
| wdata_i | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| compare_o | output | 32 | Current compare value |
| pending_o | output | 1 | Sticky timer-pending bit |
| irq_o | output | 8 | Interrupt lines; at most one is high |

## Verification
The counter is driven with plain tick runs, with a load just below the wrap point, and with ticks held under freeze. Together these separate a working increment from a stuck counter, from one that ignores freeze, and from one that misses the carry out of the top bit.

Matches are provoked in several ways: by ticking onto compare, by loading the counter straight onto compare, by leaving the counter parked on compare, and by ticking onto compare in the same cycle as a compare write. These cases tell an edge-triggered match apart from a level comparison, and a clear that has priority from one that does not. Sweeping all eight select values while the interrupt is pending shows that each line index decodes to its own line.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int unsigned CC_CNT_W   = 32;
  localparam int unsigned CC_N_LINES = 8;

  // Source that feeds the counter register on a given cycle
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_INC  = 2'd2
  } cnt_src_e;

endpackage

// File: rtl/cc_count_reg.sv
module cc_count_reg
  import cc_timer_pkg::*;
#(
  parameter int unsigned W         = CC_CNT_W,
  parameter logic [W-1:0] RESET_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         inc,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q
);

  // A load wins over an increment in the same cycle
  function automatic cnt_src_e pick_src(input logic ld, input logic up);
    if (ld)      return CNT_LOAD;
    else if (up) return CNT_INC;
    else         return CNT_HOLD;
  endfunction

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  cnt_src_e     src;
  logic [W-1:0] count_d;

  always_comb begin
    src = pick_src(load, inc);
    unique case (src)
      CNT_LOAD: count_d = load_val;
      CNT_INC:  count_d = bump(count_q);
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= RESET_VAL;
    else        count_q <= count_d;
  end

endmodule

// File: rtl/cc_match_unit.sv
module cc_match_unit
  import cc_timer_pkg::*;
#(
  parameter int unsigned W = CC_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] count_q,
  input  logic         inc_evt,
  output logic [W-1:0] compare_q,
  output logic         match_evt,
  output logic         pending_q
);

  // The match looks at the value the counter is about to take
  function automatic logic lands_on(input logic [W-1:0] cur,
                                    input logic [W-1:0] target);
    return (cur + {{(W-1){1'b0}}, 1'b1}) == target;
  endfunction

  assign match_evt = inc_evt && lands_on(count_q, compare_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      compare_q <= '0;
      pending_q <= 1'b0;
    end else begin
      if (cmp_we) compare_q <= wdata;
      if (cmp_we)         pending_q <= 1'b0;
      else if (match_evt) pending_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cc_irq_route.sv
module cc_irq_route
  import cc_timer_pkg::*;
#(
  parameter int unsigned N_LINES = CC_N_LINES,
  localparam int unsigned SEL_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [SEL_W-1:0]   sel_wdata,
  input  logic               pending,
  output logic [N_LINES-1:0] irq
);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign irq[i] = pending && (sel_q == SEL_W'(i));
  end

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = CC_CNT_W,
  parameter int unsigned N_LINES = CC_N_LINES,
  localparam int unsigned SEL_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               freeze_i,
  input  logic               cnt_we_i,
  input  logic               cmp_we_i,
  input  logic               sel_we_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   compare_o,
  output logic               pending_o,
  output logic [N_LINES-1:0] irq_o
);

  // Named internal events, brought out for the checker
  logic inc_evt;
  logic match_evt;

  assign inc_evt = tick_i && !freeze_i && !cnt_we_i;

  cc_count_reg #(.W(CNT_W), .RESET_VAL(CNT_W'(1))) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_we_i),
    .inc      (inc_evt),
    .load_val (wdata_i),
    .count_q  (count_o)
  );

  cc_match_unit #(.W(CNT_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_we    (cmp_we_i),
    .wdata     (wdata_i),
    .count_q   (count_o),
    .inc_evt   (inc_evt),
    .compare_q (compare_o),
    .match_evt (match_evt),
    .pending_q (pending_o)
  );

  cc_irq_route #(.N_LINES(N_LINES)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_we_i),
    .sel_wdata (wdata_i[SEL_W-1:0]),
    .pending   (pending_o),
    .irq       (irq_o)
  );

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               freeze_i,
  input logic               cnt_we_i,
  input logic               cmp_we_i,
  input logic [CNT_W-1:0]   wdata_i,
  input logic [CNT_W-1:0]   count_o,
  input logic               pending_o,
  input logic [N_LINES-1:0] irq_o,
  input logic               inc_evt,
  input logic               match_evt
);

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !freeze_i && !cnt_we_i) |=> count_o == $past(count_o) + 1);

  p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !cnt_we_i) |=> $stable(count_o));

  p_freeze_nomatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !pending_o) |=> !pending_o);

  p_match_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cmp_we_i) |=> pending_o);

  p_rise_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_o) |-> $past(inc_evt));

  p_irq_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_o) == (pending_o ? 1 : 0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !cmp_we_i) |=> pending_o);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i |=> (!pending_o && irq_o == '0));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> count_o == $past(wdata_i));

endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .freeze_i  (freeze_i),
  .cnt_we_i  (cnt_we_i),
  .cmp_we_i  (cmp_we_i),
  .wdata_i   (wdata_i),
  .count_o   (count_o),
  .pending_o (pending_o),
  .irq_o     (irq_o),
  .inc_evt   (inc_evt),
  .match_evt (match_evt)
);

// File: tb/cc_timer_tb.sv
`timescale 1ns/1ps
module cc_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, freeze_i, cnt_we_i, cmp_we_i, sel_we_i;
  logic [31:0] wdata_i;
  logic [31:0] count_o, compare_o;
  logic        pending_o;
  logic [7:0]  irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
    .cnt_we_i(cnt_we_i), .cmp_we_i(cmp_we_i), .sel_we_i(sel_we_i),
    .wdata_i(wdata_i), .count_o(count_o), .compare_o(compare_o),
    .pending_o(pending_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // One clock with the given inputs; outputs are sampled 1 ns after the edge
  task automatic step(input logic tk, input logic fz, input logic cw,
                      input logic mw, input logic sw, input logic [31:0] wd);
    tick_i = tk; freeze_i = fz; cnt_we_i = cw; cmp_we_i = mw;
    sel_we_i = sw; wdata_i = wd;
    @(posedge clk); #1;
    tick_i = 0; freeze_i = 0; cnt_we_i = 0; cmp_we_i = 0; sel_we_i = 0;
    wdata_i = '0;
  endtask

  task automatic t_reset;
    check("R1", "count", count_o, 32'd1);
    check("R1", "compare", compare_o, 32'd0);
    check("R1", "pending", {31'd0, pending_o}, 32'd0);
    check("R1", "irq", {24'd0, irq_o}, 32'd0);
  endtask

  task automatic t_increment;
    step(0, 0, 0, 0, 0, 0);
    check("R2", "idle hold", count_o, 32'd1);
    repeat (3) step(1, 0, 0, 0, 0, 0);
    check("R2", "three ticks", count_o, 32'd4);
    check("R2", "no pending", {31'd0, pending_o}, 32'd0);
  endtask

  task automatic t_wrap;
    step(0, 0, 1, 0, 0, 32'hFFFF_FFFF);
    check("R9", "load top", count_o, 32'hFFFF_FFFF);
    check("R5", "not yet pending", {31'd0, pending_o}, 32'd0);
    step(1, 0, 0, 0, 0, 0);
    check("R3", "wrap to zero", count_o, 32'd0);
    check("R5", "match at zero", {31'd0, pending_o}, 32'd1);
    check("R6", "line 0", {24'd0, irq_o}, 32'h01);
    step(0, 0, 0, 1, 0, 32'h100);
    check("R8", "clear pending", {31'd0, pending_o}, 32'd0);
    check("R8", "irq low", {24'd0, irq_o}, 32'd0);
    check("R8", "compare loaded", compare_o, 32'h100);
  endtask

  task automatic t_freeze;
    step(0, 0, 0, 1, 0, 32'd3);
    repeat (5) step(1, 1, 0, 0, 0, 0);
    check("R4", "frozen count", count_o, 32'd0);
    step(0, 0, 0, 1, 0, 32'd1);
    step(1, 1, 0, 0, 0, 0);
    check("R4", "frozen no match", {31'd0, pending_o}, 32'd0);
    check("R4", "frozen count 2", count_o, 32'd0);
    step(1, 0, 0, 0, 0, 0);
    check("R5", "unfrozen match", {31'd0, pending_o}, 32'd1);
    step(0, 0, 0, 1, 0, 32'd1);
    check("R8", "clear again", {31'd0, pending_o}, 32'd0);
  endtask

  task automatic t_no_refire;
    repeat (4) step(0, 0, 0, 0, 0, 0);
    check("R10", "parked on compare", {31'd0, pending_o}, 32'd0);
    step(0, 0, 0, 1, 0, 32'h50);
    step(0, 0, 1, 0, 0, 32'h50);
    check("R10", "load onto compare", {31'd0, pending_o}, 32'd0);
    check("R9", "count loaded", count_o, 32'h50);
    step(1, 0, 0, 0, 0, 0);
    check("R10", "tick past compare", {31'd0, pending_o}, 32'd0);
    check("R2", "tick 0x51", count_o, 32'h51);
  endtask

  task automatic t_load_priority;
    step(0, 0, 0, 1, 0, 32'h61);
    step(1, 0, 1, 0, 0, 32'h60);
    check("R9", "load beats tick", count_o, 32'h60);
    check("R9", "no match from load", {31'd0, pending_o}, 32'd0);
    step(1, 0, 0, 0, 0, 0);
    check("R5", "tick onto compare", {31'd0, pending_o}, 32'd1);
  endtask

  task automatic t_sticky;
    repeat (3) step(1, 0, 0, 0, 0, 0);
    check("R7", "still pending", {31'd0, pending_o}, 32'd1);
    check("R2", "count 0x64", count_o, 32'h64);
  endtask

  task automatic t_lines;
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 1, 32'(i));
      check("R6", "selected line", {24'd0, irq_o}, 32'd1 << i);
    end
  endtask

  task automatic t_same_cycle;
    step(0, 0, 0, 1, 0, 32'h66);
    check("R8", "cleared", {31'd0, pending_o}, 32'd0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 32'h200);
    check("R8", "clear beats match", {31'd0, pending_o}, 32'd0);
    check("R8", "irq stays low", {24'd0, irq_o}, 32'd0);
    check("R2", "count 0x66", count_o, 32'h66);
    check("R8", "compare 0x200", compare_o, 32'h200);
  endtask

  initial begin
    rst_n = 1'b0;
    tick_i = 0; freeze_i = 0; cnt_we_i = 0; cmp_we_i = 0; sel_we_i = 0;
    wdata_i = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_increment();
    t_wrap();
    t_freeze();
    t_no_refire();
    t_load_priority();
    t_sticky();
    t_lines();
    t_same_cycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule